// File: doc/BRIEF.md
# Speculation-Aware Set-Associative Cache Tag Controller

This block is the tag, state and replacement controller of a small set-associative data cache. Each line carries two state bits instead of a single valid bit. One is a read-allowed flag and the other is a committed flag. Together they separate lines brought in by speculative-path loads from lines that belong to the committed program path. Every request carries a path marker. The controller uses the marker and the line state to decide hit or miss, where a fill lands and how the state bits change. Lines are one data word wide. The data array is a behavioural RAM written so that block RAM can be inferred.

Data fetched by a speculative load stays in the cache as a prefetch. A later correct-path load that finds it hits, and that load promotes the line to committed. A branch squash does not invalidate anything. Speculative lines remain readable and are simply the preferred targets for the next fills. Speculative stores never touch the array or memory. Each one is parked until the branch outcome arrives, then either performed or discarded. Committed stores are written through to memory. A miss issues a one-word fetch and waits for the memory's valid strobe.

Top module: `spec_cache_ctl`

## Requirements
- R1: After synchronous reset every line is invalid, `req_ready` is 1, and `resp_valid`, `mem_req` and `mem_we` are 0; the first read of any address misses.
- R2: Line state encoding (read flag, committed flag): 0,0 invalid; 1,0 speculative (readable, preferred for replacement); 1,1 committed. The combination 0,1 never occurs.
- R3: A read accepted on a rising edge that hits a speculative or committed line of the same tag gives `resp_valid`=1, `resp_hit`=1 and the line's data one cycle later, for either path marker.
- R4: A read miss drops `req_ready` and raises `mem_req` with `mem_addr` equal to the read address one cycle after acceptance. On the edge where `mem_valid` is 1 the word is filled. One cycle later `resp_valid`=1, `resp_hit`=0, `resp_rdata` holds the fetched word and `req_ready` is 1 again.
- R5: A miss by a speculative read (`req_spec`=1) fills the line as speculative. A miss by a correct-path read fills it as committed. A later correct-path read of a speculatively filled address hits.
- R6: A correct-path read that hits a speculative line makes it committed in the same cycle. A speculative read hit leaves the state unchanged.
- R7: `resolve_squash` invalidates no line: speculative lines stay readable and keep hitting afterwards. When no speculative store is parked, `resolve_commit` and `resolve_squash` have no effect.
- R8: A fill or an allocating store chooses its way in this order: the lowest-numbered invalid way, then the lowest-numbered speculative way, then the least recently used way.
- R9: Every read hit, fill and store makes the touched way the most recently used of its set.
- R10: A correct-path store is accepted without stall. It writes its word into the hit way, or into a way allocated by R8 on a miss, and leaves that line committed. One cycle after acceptance it raises `mem_we` with `mem_waddr` and `mem_wdata` set to the store's address and data.
- R11: A speculative store parks, with `req_ready`=0, and writes neither the array nor memory. `resolve_commit` performs it as in R10, with `mem_we` one cycle after the commit. `resolve_squash` drops it. If both arrive together, squash wins. In every case `req_ready` returns one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_spec | input | 1 | 1 = request from a speculative path |
| req_addr | input | ADDR_W | Word address; low log2(SETS) bits select the set |
| req_wdata | input | DATA_W | Store data |
| resolve_commit | input | 1 | Branch resolved as predicted: perform the parked speculative store |
| resolve_squash | input | 1 | Branch mispredicted: drop the parked speculative store |
| req_ready | output | 1 | Controller can accept a request this cycle |
| resp_valid | output | 1 | Load response valid |
| resp_hit | output | 1 | Load response came from the cache |
| resp_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Fetch request to memory |
| mem_addr | output | ADDR_W | Fetch address |
| mem_valid | input | 1 | Memory returns the fetched word |
| mem_rdata | input | DATA_W | Fetched word |
| mem_we | output | 1 | Write-through strobe |
| mem_waddr | output | ADDR_W | Write-through address |
| mem_wdata | output | DATA_W | Write-through data |

## Verification
Each result appears a fixed number of cycles after its stimulus. A load hit responds one cycle after the accepting edge. A load miss raises `mem_req` one cycle after acceptance and responds one cycle after the edge that sees `mem_valid`. A store, or a commit of a parked store, shows `mem_we` one cycle later. The bench's behavioural model advances on each rising edge, using the inputs the bench drove on the previous falling edge. All outputs are compared against the model on the next falling edge, so every expected value is checked in exactly the cycle it is due. Directed sequences in one set exercise the replacement order, promotion, squash and parked stores against hard-coded expectations. A random mix of paths, stores and resolves then runs against the model.

// File: rtl/spec_cache_pkg.sv
package spec_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_HOLD  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/spec_cache_ram.sv
module spec_cache_ram #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spec_cache_victim.sv
module spec_cache_victim #(
  parameter  int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             rd_ok,
  input  logic [WAYS-1:0]             committed,
  input  logic [WAYS-1:0][WAY_W-1:0]  age,
  output logic [WAY_W-1:0]            way
);
  logic             has_inv, has_spec;
  logic [WAY_W-1:0] inv_w, spec_w, old_w;

  // descending scan: the last match seen is the lowest index
  always_comb begin
    has_inv  = 1'b0;
    has_spec = 1'b0;
    inv_w    = '0;
    spec_w   = '0;
    old_w    = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!rd_ok[w]) begin
        has_inv = 1'b1;
        inv_w   = WAY_W'(w);
      end
      if (rd_ok[w] && !committed[w]) begin
        has_spec = 1'b1;
        spec_w   = WAY_W'(w);
      end
      if (age[w] == WAY_W'(WAYS - 1)) old_w = WAY_W'(w);
    end
    way = has_inv ? inv_w : (has_spec ? spec_w : old_w);
  end
endmodule

// File: rtl/spec_cache_lru.sv
module spec_cache_lru #(
  parameter  int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] age_in,
  input  logic [WAY_W-1:0]           touch,
  output logic [WAYS-1:0][WAY_W-1:0] age_out
);
  // ages form a permutation of 0..WAYS-1; 0 is most recent
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch)           age_out[w] = '0;
      else if (age_in[w] < age_in[touch]) age_out[w] = age_in[w] + 1'b1;
      else                                age_out[w] = age_in[w];
    end
  end
endmodule

// File: rtl/spec_cache_ctl.sv
module spec_cache_ctl
  import spec_cache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_spec,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              resolve_commit,
  input  logic              resolve_squash,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int RAM_AW = IDX_W + WAY_W;

  ctl_state_e state_q;
  logic [SETS-1:0][WAYS-1:0]            rv_q, wv_q;
  logic [TAG_W-1:0]                     tag_q [SETS][WAYS];
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [ADDR_W-1:0] held_addr_q;
  logic [DATA_W-1:0] held_data_q;
  logic              fetch_spec_q;
  logic              use_ram_q;
  logic [DATA_W-1:0] byp_q;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [WAYS-1:0]   way_hit;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, vic_way, tgt_way;
  logic [WAYS-1:0][WAY_W-1:0] age_next;
  logic fire, rd_hit_ev, rd_miss_ev, spec_st_ev, st_ev, fill_ev, touch_en;
  logic [DATA_W-1:0] st_data, ram_rdata, ram_wdata;
  logic              ram_we;

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_FETCH);

  always_comb begin
    case (state_q)
      ST_HOLD:  lk_addr = held_addr_q;
      ST_FETCH: lk_addr = mem_addr;
      default:  lk_addr = req_addr;
    endcase
  end
  assign lk_set = lk_addr[IDX_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:IDX_W];

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign way_hit[g] = rv_q[lk_set][g] && (tag_q[lk_set][g] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (way_hit[w]) hit_way = WAY_W'(w);
  end
  assign hit = |way_hit;

  spec_cache_victim #(.WAYS(WAYS)) u_victim (
    .rd_ok(rv_q[lk_set]), .committed(wv_q[lk_set]), .age(age_q[lk_set]), .way(vic_way)
  );

  assign tgt_way = hit ? hit_way : vic_way;

  spec_cache_lru #(.WAYS(WAYS)) u_lru (
    .age_in(age_q[lk_set]), .touch(tgt_way), .age_out(age_next)
  );

  assign fire       = req_valid && req_ready;
  assign rd_hit_ev  = fire && !req_write && hit;
  assign rd_miss_ev = fire && !req_write && !hit;
  assign spec_st_ev = fire && req_write && req_spec;
  assign st_ev      = (fire && req_write && !req_spec) ||
                      (state_q == ST_HOLD && resolve_commit && !resolve_squash);
  assign st_data    = (state_q == ST_HOLD) ? held_data_q : req_wdata;
  assign fill_ev    = (state_q == ST_FETCH) && mem_valid;
  assign touch_en   = rd_hit_ev || st_ev || fill_ev;

  assign ram_we    = st_ev || fill_ev;
  assign ram_wdata = fill_ev ? mem_rdata : st_data;

  spec_cache_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr({lk_set, tgt_way}), .wdata(ram_wdata),
    .raddr({lk_set, hit_way}), .rdata(ram_rdata)
  );

  assign resp_rdata = use_ram_q ? ram_rdata : byp_q;

  always_ff @(posedge clk) begin
    if (st_ev || fill_ev) tag_q[lk_set][tgt_way] <= lk_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      rv_q         <= '0;
      wv_q         <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      held_addr_q  <= '0;
      held_data_q  <= '0;
      fetch_spec_q <= 1'b0;
      use_ram_q    <= 1'b0;
      byp_q        <= '0;
      resp_valid   <= 1'b0;
      resp_hit     <= 1'b0;
      mem_addr     <= '0;
      mem_we       <= 1'b0;
      mem_waddr    <= '0;
      mem_wdata    <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_we     <= 1'b0;
      if (touch_en) age_q[lk_set] <= age_next;
      if (rd_hit_ev) begin
        resp_valid <= 1'b1;
        resp_hit   <= 1'b1;
        use_ram_q  <= 1'b1;
        if (!req_spec) wv_q[lk_set][hit_way] <= 1'b1;
      end
      if (st_ev) begin
        rv_q[lk_set][tgt_way] <= 1'b1;
        wv_q[lk_set][tgt_way] <= 1'b1;
        mem_we    <= 1'b1;
        mem_waddr <= lk_addr;
        mem_wdata <= st_data;
      end
      if (fill_ev) begin
        rv_q[lk_set][tgt_way] <= 1'b1;
        wv_q[lk_set][tgt_way] <= !fetch_spec_q;
        resp_valid <= 1'b1;
        resp_hit   <= 1'b0;
        use_ram_q  <= 1'b0;
        byp_q      <= mem_rdata;
      end
      case (state_q)
        ST_IDLE: begin
          if (rd_miss_ev) begin
            state_q      <= ST_FETCH;
            mem_addr     <= req_addr;
            fetch_spec_q <= req_spec;
          end else if (spec_st_ev) begin
            state_q     <= ST_HOLD;
            held_addr_q <= req_addr;
            held_data_q <= req_wdata;
          end
        end
        ST_FETCH: if (mem_valid) state_q <= ST_IDLE;
        ST_HOLD:  if (resolve_commit || resolve_squash) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_WRITE_ONLY_STATE: assert property (@(posedge clk) disable iff (rst)
    ((~rv_q) & wv_q) == '0); // R2
  AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    rd_hit_ev |=> resp_valid && resp_hit); // R3
  AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (rst)
    rd_miss_ev |=> mem_req && !req_ready && (mem_addr == $past(req_addr))); // R4
  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_valid |=> resp_valid && !resp_hit && req_ready); // R4
  AST_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    rd_hit_ev && !req_spec |=> wv_q[$past(lk_set)][$past(hit_way)]); // R6
  AST_RV_NEVER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rv_q & $past(rv_q)) == $past(rv_q)); // R7
  AST_SPEC_STORE_HELD: assert property (@(posedge clk) disable iff (rst)
    spec_st_ev |=> !req_ready && !mem_we); // R11
  AST_SQUASH_DROPS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) && resolve_squash |=> !mem_we && req_ready); // R11
endmodule

// File: tb/spec_cache_ctl_tb_top.sv
`timescale 1ns/1ps
module spec_cache_ctl_tb_top;
  localparam int AW = 8;
  localparam int NS = 4;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_spec = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic resolve_commit = 1'b0, resolve_squash = 1'b0;
  logic req_ready, resp_valid, resp_hit, mem_req, mem_we;
  logic [31:0] resp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr, mem_waddr;
  logic mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  spec_cache_ctl #(.ADDR_W(AW), .DATA_W(32), .SETS(NS), .WAYS(NW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_spec(req_spec), .req_addr(req_addr), .req_wdata(req_wdata),
    .resolve_commit(resolve_commit), .resolve_squash(resolve_squash),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  int n_chk = 0;
  int n_err = 0;
  bit reported = 0;
  logic [31:0] bmem [256];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic logic [31:0] init_val(int a);
    return 32'hC0DE0000 | 32'(a);
  endfunction

  // memory: answers in the same cycle it sees a fetch
  always @(negedge clk) begin
    mem_valid = mem_req;
    mem_rdata = bmem[mem_addr];
  end

  // ---------------- behavioural reference model ----------------
  int  mtag [NS][NW];
  bit  mrv  [NS][NW];
  bit  mwv  [NS][NW];
  longint stamp [NS][NW];
  longint tick = 0;
  int  m_st = 0;          // 0 idle, 1 fetching, 2 parked store
  int  m_addr = 0;
  bit  m_spec = 0;
  logic [31:0] m_hdata = '0;
  bit  e_ready = 1, e_mreq = 0, e_valid = 0, e_hit = 0, e_we = 0;
  logic [31:0] e_data = '0, e_wd = '0;
  int  e_wa = 0;

  function automatic int m_find(int s, int t);
    for (int w = 0; w < NW; w++) if (mrv[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int m_victim(int s);
    int best;
    for (int w = 0; w < NW; w++) if (!mrv[s][w]) return w;
    for (int w = 0; w < NW; w++) if (!mwv[s][w]) return w;
    best = 0;
    for (int w = 1; w < NW; w++) if (stamp[s][w] < stamp[s][best]) best = w;
    return best;
  endfunction

  task automatic m_touch(int s, int w);
    tick++;
    stamp[s][w] = tick;
  endtask

  task automatic m_store(int a, logic [31:0] d);
    int s, t, w;
    s = a % NS; t = a / NS;
    w = m_find(s, t);
    if (w < 0) w = m_victim(s);
    mtag[s][w] = t; mrv[s][w] = 1; mwv[s][w] = 1;
    m_touch(s, w);
    bmem[a] = d;
    e_we = 1; e_wa = a; e_wd = d;
  endtask

  always @(posedge clk) begin
    int a, s, w;
    if (rst) begin
      for (int i = 0; i < NS; i++)
        for (int j = 0; j < NW; j++) begin
          mrv[i][j] = 0; mwv[i][j] = 0; mtag[i][j] = 0; stamp[i][j] = 0;
        end
      m_st = 0; e_valid = 0; e_we = 0;
    end else begin
      e_valid = 0; e_we = 0;
      case (m_st)
        0: if (req_valid) begin
          a = int'(req_addr); s = a % NS;
          w = m_find(s, a / NS);
          if (req_write) begin
            if (req_spec) begin m_st = 2; m_addr = a; m_hdata = req_wdata; end
            else m_store(a, req_wdata);
          end else if (w >= 0) begin
            e_valid = 1; e_hit = 1; e_data = bmem[a];
            m_touch(s, w);
            if (!req_spec) mwv[s][w] = 1;
          end else begin
            m_st = 1; m_addr = a; m_spec = req_spec;
          end
        end
        1: begin
          s = m_addr % NS;
          w = m_victim(s);
          mtag[s][w] = m_addr / NS; mrv[s][w] = 1; mwv[s][w] = !m_spec;
          m_touch(s, w);
          e_valid = 1; e_hit = 0; e_data = bmem[m_addr];
          m_st = 0;
        end
        default: begin
          if (resolve_squash) m_st = 0;
          else if (resolve_commit) begin m_store(m_addr, m_hdata); m_st = 0; end
        end
      endcase
      e_ready = (m_st == 0);
      e_mreq  = (m_st == 1);
    end
  end

  // cycle-by-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R4 R11 req_ready", req_ready, e_ready);
      check("R4 mem_req", mem_req, e_mreq);
      check("R3 resp_valid", resp_valid, e_valid);
      if (e_valid && resp_valid) begin
        check("R8 R9 resp_hit", resp_hit, e_hit);
        check("R3 resp_rdata", resp_rdata, e_data);
      end
      check("R10 mem_we", mem_we, e_we);
      if (e_we && mem_we) begin
        check("R10 mem_waddr", 32'(mem_waddr), 32'(e_wa));
        check("R10 mem_wdata", mem_wdata, e_wd);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit wr, input bit sp, input int a, input logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_spec = sp; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pulse(input bit c, input bit q);
    @(negedge clk);
    resolve_commit = c; resolve_squash = q;
    @(negedge clk);
    resolve_commit = 0; resolve_squash = 0;
  endtask

  task automatic rd_expect(input string tag, input int a, input bit sp,
                           input bit exp_hit, input logic [31:0] exp_data);
    bit got;
    issue(0, sp, a, 0);
    got = 0;
    for (int k = 0; k < 4 && !got; k++) begin
      if (resp_valid) begin
        got = 1;
        check({tag, " hit"}, resp_hit, exp_hit);
        check({tag, " data"}, resp_rdata, exp_data);
      end else @(negedge clk);
    end
    if (!got) check({tag, " response"}, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int a = 0; a < 256; a++) bmem[a] = init_val(a);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R1 resp_valid after reset", resp_valid, 0);
    check("R1 mem_req after reset", mem_req, 0);
    check("R1 mem_we after reset", mem_we, 0);

    // set 0, addresses 4*t
    rd_expect("R1 R4 first read misses", 4, 0, 0, init_val(4));
    rd_expect("R3 committed hit", 4, 0, 1, init_val(4));
    rd_expect("R5 spec miss", 8, 1, 0, init_val(8));
    rd_expect("R5 R2 prefetch reused", 8, 0, 1, init_val(8));
    rd_expect("R5 spec miss 2", 12, 1, 0, init_val(12));
    pulse(0, 1);
    rd_expect("R7 spec line readable after squash", 12, 1, 1, init_val(12));
    rd_expect("R8 invalid way taken", 16, 0, 0, init_val(16));
    rd_expect("R8 full set miss", 20, 0, 0, init_val(20));
    rd_expect("R6 promoted line kept", 8, 0, 1, init_val(8));
    rd_expect("R2 R8 spec line was victim", 12, 0, 0, init_val(12));
    rd_expect("R9 LRU line evicted", 4, 0, 0, init_val(4));
    rd_expect("R9 recent line kept", 20, 0, 1, init_val(20));
    rd_expect("R9 next LRU evicted", 16, 0, 0, init_val(16));

    issue(1, 0, 20, 32'h11110005);
    check("R10 write-through strobe", mem_we, 1);
    check("R10 write-through data", mem_wdata, 32'h11110005);
    rd_expect("R10 store hit updates line", 20, 0, 1, 32'h11110005);

    issue(1, 1, 24, 32'h22220006);
    check("R11 parked store stalls", req_ready, 0);
    check("R11 parked store no write", mem_we, 0);
    repeat (3) @(negedge clk);
    check("R11 still parked", req_ready, 0);
    pulse(0, 1);
    check("R11 squash no write", mem_we, 0);
    rd_expect("R11 squashed store dropped", 24, 0, 0, init_val(24));

    issue(1, 1, 20, 32'h33330005);
    pulse(1, 0);
    check("R11 commit writes through", mem_we, 1);
    check("R11 commit data", mem_wdata, 32'h33330005);
    rd_expect("R11 committed store visible", 20, 0, 1, 32'h33330005);

    issue(1, 1, 20, 32'h44440005);
    pulse(1, 1);
    check("R11 squash beats commit", mem_we, 0);
    rd_expect("R11 squash beats commit data", 20, 0, 1, 32'h33330005);

    issue(1, 0, 28, 32'h55550007);
    rd_expect("R10 store miss allocates", 28, 0, 1, 32'h55550007);
    pulse(1, 0);
    check("R7 idle commit ignored", mem_we, 0);

    for (int i = 0; i < 400; i++) begin
      int a, r;
      bit wr, sp;
      a  = $urandom_range(0, 47);
      wr = ($urandom_range(0, 3) == 0);
      sp = ($urandom_range(0, 2) == 0);
      if (wr) begin
        issue(1, sp, a, $urandom);
        if (sp) begin
          repeat ($urandom_range(0, 2)) @(negedge clk);
          r = $urandom_range(0, 2);
          pulse(r != 1, r != 0);
        end
      end else begin
        issue(0, sp, a, 0);
      end
      if ($urandom_range(0, 9) == 0) pulse(0, 1);
    end
    repeat (4) @(negedge clk);
    report();
  end
endmodule